// File: doc/BRIEF.md
# Shared-Timer Pin Debouncer

This block filters contact bounce and noise on a group of general-purpose input pins before other logic sees them. Each pin passes through a synchroniser and then a per-pin filter. The filter copies a new level to the pin's output only after the synchronised input has differed from the current output for a programmed number of clock cycles. Three period registers are shared by all pins. Each pin chooses one of them, or none. With no period chosen, the pin bypasses the filter and its output tracks the synchronised input one cycle later.

A pin's choice is a 2-bit index made from two select registers. The first select register holds the high bit of every pin's index and the second holds the low bit, each at the pin's bit position. Software programs the registers through a plain addressed write strobe. Register contents are visible on a combinational read port.

Top module: `pin_debounce_bank`

## Requirements
- R1: After reset every register reads as zero and every debounced output is 0.
- R2: Register offsets are 0x00 (index high bits), 0x04 (index low bits), 0x50 (period A), 0x54 (period B) and 0x58 (period C). Each of these reads back what was last written to it. Any other offset reads as zero, and writes to it change no register.
- R3: The index of pin p is {reg0x00[p], reg0x04[p]}. Index 1 selects period A, index 2 selects period B and index 3 selects period C.
- R4: A pin with index 0 is unfiltered. Its output takes the raw level 3 cycles after the raw input changes, so even a 1-cycle pulse reaches the output.
- R5: With a selected period N (N ≥ 1), a raw level held for at least N cycles appears at the output 2+N cycles after the raw change. A period value of 0 behaves as 1.
- R6: With a selected period N, a raw pulse that lasts fewer than N cycles never reaches the output.
- R7: Rewriting a period register while a pin is counting toward a change leaves that count unchanged. The new value applies from the next time the pin's input and output agree.
- R8: Activity on one pin never changes the output of another pin.
- R9: An output bit changes only to the value its synchronised input had in the previous cycle, and only when that input differed from the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Byte offset used for both writes and reads |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data for `addr` |
| pin_raw | input | NPINS (32) | Asynchronous raw pin levels |
| pin_dbc | output | NPINS (32) | Debounced pin levels |

## Verification
The hardest situation to reach from the ports is a period register rewritten while a pin is partway through a count, because the count itself cannot be observed. The bench raises a pin that uses period B and, in a parallel thread, writes a much shorter period a few cycles later. It then measures the exact output latency, which must still match the old period. A second transition is then timed against the new period. Pulses one cycle shorter than each period and pulses exactly equal to it show where the threshold lies. Pins are given asymmetric indices, so a swapped high and low select bit selects a different period and is detected.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    localparam int unsigned NUM_TIMERS = 3;

    localparam logic [15:0] OFS_IDX_HI = 16'h0000;
    localparam logic [15:0] OFS_IDX_LO = 16'h0004;
    localparam logic [15:0] OFS_PER_A  = 16'h0050;
    localparam logic [15:0] OFS_PER_B  = 16'h0054;
    localparam logic [15:0] OFS_PER_C  = 16'h0058;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_PER_A = 2'd1,
        MODE_PER_B = 2'd2,
        MODE_PER_C = 2'd3
    } dbc_mode_e;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_IDX_HI,
        RS_IDX_LO,
        RS_PER_A,
        RS_PER_B,
        RS_PER_C
    } reg_sel_e;

    // High select register supplies bit 1 of the index, low register bit 0.
    function automatic dbc_mode_e mode_of(input logic hi_bit, input logic lo_bit);
        return dbc_mode_e'({hi_bit, lo_bit});
    endfunction

    function automatic reg_sel_e decode_addr(input logic [15:0] a);
        reg_sel_e r;
        case (a)
            OFS_IDX_HI: r = RS_IDX_HI;
            OFS_IDX_LO: r = RS_IDX_LO;
            OFS_PER_A:  r = RS_PER_A;
            OFS_PER_B:  r = RS_PER_B;
            OFS_PER_C:  r = RS_PER_C;
            default:    r = RS_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pdb_regfile.sv
module pdb_regfile
    import pdb_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    wr_en,
    input  logic [ADDR_W-1:0]                       addr,
    input  logic [DATA_W-1:0]                       wdata,
    output logic [DATA_W-1:0]                       rdata,
    output logic [NPINS-1:0]                        idx_hi,
    output logic [NPINS-1:0]                        idx_lo,
    output logic [NUM_TIMERS-1:0][DATA_W-1:0]       periods
);

    reg_sel_e sel;

    always_comb sel = decode_addr(16'(addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_hi  <= '0;
            idx_lo  <= '0;
            periods <= '0;
        end else if (wr_en) begin
            case (sel)
                RS_IDX_HI: idx_hi     <= wdata[NPINS-1:0];
                RS_IDX_LO: idx_lo     <= wdata[NPINS-1:0];
                RS_PER_A:  periods[0] <= wdata;
                RS_PER_B:  periods[1] <= wdata;
                RS_PER_C:  periods[2] <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            RS_IDX_HI: rdata = DATA_W'(idx_hi);
            RS_IDX_LO: rdata = DATA_W'(idx_lo);
            RS_PER_A:  rdata = periods[0];
            RS_PER_B:  rdata = periods[1];
            RS_PER_C:  rdata = periods[2];
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/pdb_sync.sv
module pdb_sync #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] din,
    output logic [NPINS-1:0] dout
);

    logic [NPINS-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/pdb_lane.sv
module pdb_lane
    import pdb_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  dbc_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    output logic             dout
);

    logic [CNT_W-1:0] remain;

    // The count reloads every cycle in which input and output agree, so a
    // period rewrite only applies from the next agreement.
    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= 1'b0;
            remain <= '0;
        end else if (din == dout) begin
            remain <= period;
        end else if (mode == MODE_OFF || remain <= CNT_W'(1)) begin
            dout   <= din;
            remain <= period;
        end else begin
            remain <= remain - CNT_W'(1);
        end
    end

endmodule

// File: rtl/pin_debounce_bank.sv
module pin_debounce_bank
    import pdb_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPINS-1:0]  pin_raw,
    output logic [NPINS-1:0]  pin_dbc
);

    logic [NPINS-1:0]                  idx_hi_q;
    logic [NPINS-1:0]                  idx_lo_q;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] tmr_q;
    logic [NPINS-1:0]                  sync_q;

    pdb_regfile #(
        .NPINS  (NPINS),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .idx_hi  (idx_hi_q),
        .idx_lo  (idx_lo_q),
        .periods (tmr_q)
    );

    pdb_sync #(
        .NPINS  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_raw),
        .dout (sync_q)
    );

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_lane
            dbc_mode_e         mode;
            logic [DATA_W-1:0] period;

            always_comb begin
                mode = mode_of(idx_hi_q[p], idx_lo_q[p]);
                case (mode)
                    MODE_PER_A: period = tmr_q[0];
                    MODE_PER_B: period = tmr_q[1];
                    MODE_PER_C: period = tmr_q[2];
                    default:    period = '0;
                endcase
            end

            pdb_lane #(
                .CNT_W (DATA_W)
            ) u_lane (
                .clk    (clk),
                .rst    (rst),
                .din    (sync_q[p]),
                .mode   (mode),
                .period (period),
                .dout   (pin_dbc[p])
            );
        end
    endgenerate

endmodule

// File: rtl/pdb_checker.sv
module pdb_checker
    import pdb_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              wr_en,
    input logic [ADDR_W-1:0]                 addr,
    input logic [DATA_W-1:0]                 rdata,
    input logic [NPINS-1:0]                  idx_hi,
    input logic [NPINS-1:0]                  idx_lo,
    input logic [NUM_TIMERS-1:0][DATA_W-1:0] tmr,
    input logic [NPINS-1:0]                  sync_q,
    input logic [NPINS-1:0]                  pin_dbc
);

    logic mapped;
    always_comb mapped = (addr == ADDR_W'(8'h00)) || (addr == ADDR_W'(8'h04)) ||
                         (addr == ADDR_W'(8'h50)) || (addr == ADDR_W'(8'h54)) ||
                         (addr == ADDR_W'(8'h58));

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_dbc == '0 && idx_hi == '0 && idx_lo == '0 && tmr == '0));

    p_regs_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable({idx_hi, idx_lo, tmr}));

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> rdata == '0);

    p_mode_off_follow_r4: assert property (@(posedge clk) disable iff (rst)
        ((pin_dbc ^ $past(sync_q)) & $past(~(idx_hi | idx_lo))) == '0);

    p_change_needs_mismatch_r9: assert property (@(posedge clk) disable iff (rst)
        ((pin_dbc ^ $past(pin_dbc)) & ~($past(sync_q) ^ $past(pin_dbc))) == '0);

endmodule

bind pin_debounce_bank pdb_checker #(
    .NPINS  (NPINS),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .idx_hi  (idx_hi_q),
    .idx_lo  (idx_lo_q),
    .tmr     (tmr_q),
    .sync_q  (sync_q),
    .pin_dbc (pin_dbc)
);

// File: tb/pin_debounce_bank_test.sv
module pin_debounce_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] raw = '0;
    logic [31:0] dout;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pin_debounce_bank uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_raw (raw),
        .pin_dbc (dout)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // Toggle one raw pin and count cycles until its output follows.
    task automatic latency(input int pin, output int k);
        logic prev;
        @(negedge clk);
        prev = dout[pin];
        raw[pin] = ~raw[pin];
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (dout[pin] == prev && k < 200);
    endtask

    task automatic pulse(input int pin, input int w, output bit seen);
        @(negedge clk);
        raw[pin] = 1'b1;
        seen = 1'b0;
        repeat (w) begin
            @(negedge clk);
            if (dout[pin]) seen = 1'b1;
        end
        raw[pin] = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (dout[pin]) seen = 1'b1;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk(dout == '0, "R1 outputs after reset", dout, 0);
        rd(8'h00, d); chk(d == 0, "R1 reg 0x00", d, 0);
        rd(8'h04, d); chk(d == 0, "R1 reg 0x04", d, 0);
        rd(8'h50, d); chk(d == 0, "R1 reg 0x50", d, 0);
        rd(8'h54, d); chk(d == 0, "R1 reg 0x54", d, 0);
        rd(8'h58, d); chk(d == 0, "R1 reg 0x58", d, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr(8'h00, 32'hA5A5_0F0F);
        wr(8'h04, 32'h3C3C_F0F0);
        wr(8'h50, 32'h1234_5678);
        wr(8'h54, 32'h0BAD_CAFE);
        wr(8'h58, 32'h0000_0101);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h5C, 32'hFFFF_FFFF);
        rd(8'h00, d); chk(d == 32'hA5A5_0F0F, "R2 readback 0x00", d, 32'hA5A5_0F0F);
        rd(8'h04, d); chk(d == 32'h3C3C_F0F0, "R2 readback 0x04", d, 32'h3C3C_F0F0);
        rd(8'h50, d); chk(d == 32'h1234_5678, "R2 readback 0x50", d, 32'h1234_5678);
        rd(8'h54, d); chk(d == 32'h0BAD_CAFE, "R2 readback 0x54", d, 32'h0BAD_CAFE);
        rd(8'h58, d); chk(d == 32'h0000_0101, "R2 readback 0x58", d, 32'h0000_0101);
        rd(8'h08, d); chk(d == 0, "R2 unmapped 0x08", d, 0);
        rd(8'h5C, d); chk(d == 0, "R2 unmapped 0x5C", d, 0);
        chk(dout == '0, "R2 outputs untouched by writes", dout, 0);
        wr(8'h00, 0); wr(8'h04, 0); wr(8'h50, 0); wr(8'h54, 0); wr(8'h58, 0);
    endtask

    task automatic t_passthru;
        int k;
        bit seen;
        latency(0, k); chk(k == 3, "R4 unfiltered rise latency", k, 3);
        chk(dout == 32'h1, "R8 only pin 0 high", dout, 32'h1);
        latency(0, k); chk(k == 3, "R4 unfiltered fall latency", k, 3);
        pulse(0, 1, seen); chk(seen, "R4 one-cycle pulse passes", seen, 1);
    endtask

    task automatic t_mapping;
        int k;
        wr(8'h50, 4); wr(8'h54, 7); wr(8'h58, 11);
        wr(8'h00, (32'h1 << 3) | (32'h1 << 9));
        wr(8'h04, (32'h1 << 5) | (32'h1 << 9));
        latency(3, k); chk(k == 9, "R3 index 2 uses period B (pin 3)", k, 9);
        latency(3, k); chk(k == 9, "R5 fall with period B", k, 9);
        latency(5, k); chk(k == 6, "R3 index 1 uses period A (pin 5)", k, 6);
        latency(5, k); chk(k == 6, "R5 fall with period A", k, 6);
        latency(9, k); chk(k == 13, "R3 index 3 uses period C (pin 9)", k, 13);
        chk(dout == (32'h1 << 9), "R8 pin 9 alone high", dout, 32'h1 << 9);
        latency(9, k); chk(k == 13, "R5 fall with period C", k, 13);
        latency(0, k); chk(k == 3, "R3 index 0 stays unfiltered", k, 3);
        latency(0, k);
    endtask

    task automatic t_glitch;
        bit seen;
        pulse(5, 3, seen);  chk(!seen, "R6 3-cycle pulse blocked by period 4", seen, 0);
        pulse(5, 4, seen);  chk(seen, "R5 4-cycle pulse passes period 4", seen, 1);
        pulse(3, 6, seen);  chk(!seen, "R6 6-cycle pulse blocked by period 7", seen, 0);
        pulse(3, 7, seen);  chk(seen, "R5 7-cycle pulse passes period 7", seen, 1);
        pulse(9, 10, seen); chk(!seen, "R6 10-cycle pulse blocked by period 11", seen, 0);
        pulse(9, 11, seen); chk(seen, "R5 11-cycle pulse passes period 11", seen, 1);
        chk(dout == '0, "R8 all outputs settle low", dout, 0);
    endtask

    task automatic t_zero_period;
        int k;
        wr(8'h50, 0);
        latency(5, k); chk(k == 3, "R5 zero period acts as one", k, 3);
        latency(5, k);
        wr(8'h50, 4);
    endtask

    task automatic t_rewrite;
        int k;
        fork
            latency(3, k);
            begin
                repeat (4) @(negedge clk);
                wr(8'h54, 2);
            end
        join
        chk(k == 9, "R7 count in progress keeps old period", k, 9);
        latency(3, k); chk(k == 4, "R7 next change uses new period", k, 4);
        wr(8'h54, 7);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_passthru();
        t_mapping();
        t_glitch();
        t_zero_period();
        t_rewrite();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule